// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

This engine sits on the device side of a transmit path and walks a ring of buffer descriptors that the host keeps in its own memory. The ring has a power-of-two number of slots. Its default is 512, and all index arithmetic wraps at that size. The host fills slots and then announces them by writing a new producer index into a mailbox input. When the engine's consumer index differs from that producer value, it issues one four-word read for the descriptor at the consumer slot. It decodes the returned words and offers the buffer address, frame length, flag bits and an end-of-frame marker on a valid/ready stream toward the MAC.

After the MAC side accepts a descriptor, the consumer index steps forward. The engine publishes the index in the upper half of a 32-bit status word, and the host frees buffers up to that point. The host counts the ring as full when its next producer value would equal the published index, so one slot always stays empty. Payload movement, bus protocol details, checksum handling and more than one ring belong to other blocks.

Top module: `txdesc_fetch`

## Requirements
- R1: While reset (synchronous, active low) is asserted, and in the first cycle after it is released, the producer and consumer indices are zero, `status_word` is 0, and neither `rd_req_valid` nor `tx_valid` is high.
- R2: A mailbox write loads `mbox_idx` as the producer index on the next clock edge. The engine issues no read request while the consumer index equals the producer index. A rewrite of the current producer value therefore starts no read.
- R3: Each descriptor takes exactly one read request, at address `ring_base + index*16`. The request is held, with its address unchanged, until `rd_req_ready` accepts it.
- R4: The four response words are taken in order (word 0 first) on the cycles where `rd_rsp_valid` is high. Idle cycles may appear before or between the words.
- R5: Decode: `tx_addr` is word 0 (upper 32 bits) followed by word 1 (lower 32 bits), `tx_len` is word 2 bits 31:16, and `tx_flags` is word 2 bits 15:0.
- R6: `tx_last` equals bit 2 of word 2. A descriptor with that bit clear is forwarded with `tx_last`=0 so that fragments can be chained.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and every output field stays unchanged.
- R8: `status_word` bits 31:16 hold the consumer index, zero-extended, and bits 15:0 are 0. The index grows by one in the cycle after each `tx_valid`&`tx_ready` handshake and changes at no other time.
- R9: The consumer index wraps from ring size minus one to 0, and the next read address after the wrap is `ring_base`.
- R10: A ring posted with the largest legal count (ring size minus one descriptors in one mailbox write) is consumed completely and in slot order.
- R11: The contents of word 3 (reserved) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ring_base | input | 64 | Byte address of ring slot 0, 16-byte aligned |
| mbox_wr | input | 1 | Host write strobe for the producer mailbox |
| mbox_idx | input | 9 | Producer index written by the host |
| rd_req_valid | output | 1 | Four-word read request pending |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 64 | Byte address of the descriptor to read |
| rd_rsp_valid | input | 1 | A response word is present |
| rd_rsp_data | input | 32 | Response word, delivered in order |
| tx_valid | output | 1 | Decoded descriptor available |
| tx_ready | input | 1 | MAC side accepts the descriptor |
| tx_addr | output | 64 | Buffer address |
| tx_len | output | 16 | Frame length in bytes |
| tx_flags | output | 16 | Low half of the length/flags word |
| tx_last | output | 1 | End of frame |
| status_word | output | 32 | Consumer index in bits 31:16 |

## Verification
Two conditions are hard to reach from the ports: the wrap of the consumer index, and a ring that holds its full 511 descriptors. The stimulus holds `tx_ready` low and waits until the ring is empty. It then posts 511 slots in one mailbox write, so the engine stalls at the first descriptor while every other slot is pending. It then releases the downstream side with random back-pressure, so the drain runs through slot 511 and on to slot 0 under load. Random gaps in request acceptance and response words are applied over further streaming traffic. Word 3 always carries nonzero data, and a fragment mode clears bit 2 on most descriptors.

// File: rtl/txf_pkg.sv
// Shared types for the transmit descriptor fetch engine.
// Assumes a descriptor address of 64 bits and a 16-bit length field.
package txf_pkg;

    localparam int TXF_ADDR_W = 64;
    localparam int TXF_HALF_W = 16;
    localparam int TXF_WORD_W = 32;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_REQ  = 2'd1,
        RD_DATA = 2'd2,
        RD_HOLD = 2'd3
    } rd_state_e;

    typedef struct packed {
        logic [TXF_ADDR_W-1:0] addr;
        logic [TXF_HALF_W-1:0] len;
        logic [TXF_HALF_W-1:0] flags;
        logic                  last;
    } txd_s;

endpackage

// File: rtl/txf_mailbox.sv
// Producer mailbox: holds the last index the host wrote and flags an
// empty ring when it matches the engine's consumer index.
// Assumes the host never posts past the slot it has reclaimed.
module txf_mailbox #(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDX_W-1:0] cons_idx,
    output logic [IDX_W-1:0] prod_idx,
    output logic             ring_empty
);

    logic [IDX_W-1:0] prod_q;

    // Capture the producer index on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
        end else if (wr) begin
            prod_q <= wr_idx;
        end
    end

    // Empty whenever the consumer has caught up with the producer.
    always_comb begin
        ring_empty = (prod_q == cons_idx);
    end

    assign prod_idx = prod_q;

    p_prod_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> prod_idx == $past(wr_idx));

endmodule

// File: rtl/txf_reader.sv
// Descriptor reader: issues one multi-word read per ring slot, gathers
// the response words in order and holds them until the downstream
// handshake retires the slot. Only one descriptor is in flight.
// Assumes responses arrive in order and only after a request is taken;
// the last word (reserved) is counted but not stored.
module txf_reader
    import txf_pkg::*;
#(
    parameter int IDX_W   = 9,
    parameter int BASE_W  = 64,
    parameter int NWORDS  = 4,
    parameter int NKEEP   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [BASE_W-1:0]          ring_base,
    input  logic [IDX_W-1:0]           cons_idx,
    input  logic                       ring_empty,
    output logic                       req_valid,
    input  logic                       req_ready,
    output logic [BASE_W-1:0]          req_addr,
    input  logic                       rsp_valid,
    input  logic [TXF_WORD_W-1:0]      rsp_data,
    output logic                       desc_valid,
    input  logic                       desc_taken,
    output logic [NKEEP*TXF_WORD_W-1:0] words
);

    localparam int WCNT_W = $clog2(NWORDS);
    localparam int OFS_SH = $clog2(NWORDS * TXF_WORD_W / 8);
    localparam logic [WCNT_W-1:0] LAST_W = WCNT_W'(NWORDS - 1);

    rd_state_e         state_q;
    rd_state_e         state_d;
    logic [WCNT_W-1:0] wcnt_q;
    logic              take_word;

    assign take_word = (state_q == RD_DATA) && rsp_valid;

    // Next-state selection for the fetch sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (!ring_empty)                   state_d = RD_REQ;
            RD_REQ:  if (req_ready)                     state_d = RD_DATA;
            RD_DATA: if (take_word && wcnt_q == LAST_W) state_d = RD_HOLD;
            RD_HOLD: if (desc_taken)                    state_d = RD_IDLE;
            default:                                    state_d = RD_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Word counter: cleared on request acceptance, stepped per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
        end else if (state_q == RD_REQ && req_ready) begin
            wcnt_q <= '0;
        end else if (take_word) begin
            wcnt_q <= wcnt_q + 1'b1;
        end
    end

    // One capture register per kept word.
    for (genvar g = 0; g < NKEEP; g++) begin : g_word
        logic [TXF_WORD_W-1:0] wbuf_q;

        // Store this word when its position comes up.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wbuf_q <= '0;
            end else if (take_word && wcnt_q == WCNT_W'(g)) begin
                wbuf_q <= rsp_data;
            end
        end

        assign words[g*TXF_WORD_W +: TXF_WORD_W] = wbuf_q;
    end

    // Slot address: base plus index scaled by descriptor size.
    always_comb begin
        req_addr = ring_base + BASE_W'({cons_idx, {OFS_SH{1'b0}}});
    end

    assign req_valid  = (state_q == RD_REQ);
    assign desc_valid = (state_q == RD_HOLD);

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr));

    p_req_needs_work_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !ring_empty);

    p_hold_until_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && !desc_taken |=> desc_valid && $stable(words));

endmodule

// File: rtl/txf_decode.sv
// Field decode of a gathered descriptor: 64-bit address from the first
// two words, length and flags from the third, end-of-frame from a flag bit.
// Purely combinational; assumes words arrive packed with word 0 lowest.
module txf_decode
    import txf_pkg::*;
#(
    parameter int NKEEP   = 3,
    parameter int EOP_BIT = 2
) (
    input  logic [NKEEP*TXF_WORD_W-1:0] words,
    output txd_s                        desc
);

    logic [TXF_WORD_W-1:0] w_hi;
    logic [TXF_WORD_W-1:0] w_lo;
    logic [TXF_WORD_W-1:0] w_ctl;

    assign w_hi  = words[0*TXF_WORD_W +: TXF_WORD_W];
    assign w_lo  = words[1*TXF_WORD_W +: TXF_WORD_W];
    assign w_ctl = words[2*TXF_WORD_W +: TXF_WORD_W];

    // Split the words into output fields.
    always_comb begin
        desc.addr  = {w_hi, w_lo};
        desc.len   = w_ctl[TXF_WORD_W-1 -: TXF_HALF_W];
        desc.flags = w_ctl[TXF_HALF_W-1:0];
        desc.last  = w_ctl[EOP_BIT];
    end

endmodule

// File: rtl/txf_status.sv
// Consumer index and the host-visible status word. The index advances
// once per retired descriptor and wraps at the ring size.
// Assumes IDX_W is below 16 so the index fits the upper half-word.
module txf_status
    import txf_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  advance,
    output logic [IDX_W-1:0]      cons_idx,
    output logic [TXF_WORD_W-1:0] status_word
);

    logic [IDX_W-1:0] cons_q;

    // Step the consumer index on each retired descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cons_q <= '0;
        end else if (advance) begin
            cons_q <= cons_q + 1'b1;
        end
    end

    // Place the index in the upper half of the status word.
    always_comb begin
        status_word = {{(TXF_HALF_W-IDX_W){1'b0}}, cons_q, {TXF_HALF_W{1'b0}}};
    end

    assign cons_idx = cons_q;

    p_status_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> cons_idx == IDX_W'($past(cons_idx) + 1'b1));

    p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(status_word));

endmodule

// File: rtl/txdesc_fetch.sv
// Transmit descriptor fetch engine top level. Connects the producer
// mailbox, the single-outstanding reader, the field decoder and the
// consumer/status register. Assumes a 16-byte aligned ring base and a
// host that keeps one ring slot unused.
module txdesc_fetch
    import txf_pkg::*;
#(
    parameter int IDX_W   = 9,
    parameter int NWORDS  = 4,
    parameter int EOP_BIT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TXF_ADDR_W-1:0] ring_base,
    input  logic                  mbox_wr,
    input  logic [IDX_W-1:0]      mbox_idx,
    output logic                  rd_req_valid,
    input  logic                  rd_req_ready,
    output logic [TXF_ADDR_W-1:0] rd_req_addr,
    input  logic                  rd_rsp_valid,
    input  logic [TXF_WORD_W-1:0] rd_rsp_data,
    output logic                  tx_valid,
    input  logic                  tx_ready,
    output logic [TXF_ADDR_W-1:0] tx_addr,
    output logic [TXF_HALF_W-1:0] tx_len,
    output logic [TXF_HALF_W-1:0] tx_flags,
    output logic                  tx_last,
    output logic [TXF_WORD_W-1:0] status_word
);

    localparam int NKEEP = NWORDS - 1;

    logic [IDX_W-1:0]            cons_idx;
    logic [IDX_W-1:0]            prod_idx;
    logic                        ring_empty;
    logic                        retire;
    logic [NKEEP*TXF_WORD_W-1:0] words;
    txd_s                        desc;

    assign retire = tx_valid && tx_ready;

    txf_mailbox #(.IDX_W(IDX_W)) u_mbox (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (mbox_wr),
        .wr_idx     (mbox_idx),
        .cons_idx   (cons_idx),
        .prod_idx   (prod_idx),
        .ring_empty (ring_empty)
    );

    txf_reader #(
        .IDX_W  (IDX_W),
        .BASE_W (TXF_ADDR_W),
        .NWORDS (NWORDS),
        .NKEEP  (NKEEP)
    ) u_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .ring_base  (ring_base),
        .cons_idx   (cons_idx),
        .ring_empty (ring_empty),
        .req_valid  (rd_req_valid),
        .req_ready  (rd_req_ready),
        .req_addr   (rd_req_addr),
        .rsp_valid  (rd_rsp_valid),
        .rsp_data   (rd_rsp_data),
        .desc_valid (tx_valid),
        .desc_taken (retire),
        .words      (words)
    );

    txf_decode #(.NKEEP(NKEEP), .EOP_BIT(EOP_BIT)) u_decode (
        .words (words),
        .desc  (desc)
    );

    txf_status #(.IDX_W(IDX_W)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .advance     (retire),
        .cons_idx    (cons_idx),
        .status_word (status_word)
    );

    assign tx_addr  = desc.addr;
    assign tx_len   = desc.len;
    assign tx_flags = desc.flags;
    assign tx_last  = desc.last;

    p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_addr) && $stable(tx_len)
                                  && $stable(tx_flags) && $stable(tx_last));

    p_no_fetch_while_holding_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rd_req_valid);

    p_retire_needs_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> prod_idx != cons_idx);

endmodule

// File: tb/txdesc_fetch_tb_top.sv
`timescale 1ns/1ps
module txdesc_fetch_tb_top;

    localparam int RING = 512;
    localparam logic [63:0] BASE = 64'h0000_0012_3450_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mbox_wr = 1'b0;
    logic [8:0]  mbox_idx = '0;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b0;
    logic [63:0] rd_req_addr;
    logic        rd_rsp_valid = 1'b0;
    logic [31:0] rd_rsp_data = '0;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [63:0] tx_addr;
    logic [15:0] tx_len;
    logic [15:0] tx_flags;
    logic        tx_last;
    logic [31:0] status_word;

    always #2 clk = ~clk;

    txdesc_fetch dut_i (
        .clk(clk), .rst_n(rst_n), .ring_base(BASE),
        .mbox_wr(mbox_wr), .mbox_idx(mbox_idx),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_addr(tx_addr), .tx_len(tx_len),
        .tx_flags(tx_flags), .tx_last(tx_last), .status_word(status_word)
    );

    // Reference model state
    logic [31:0] mem_w [RING][4];
    int checks = 0, errors = 0, cyc = 0;
    int exp_cons = 0, prod_m = 0, seq = 0, done_cnt = 0, wraps = 0;
    int post_req = 0;
    bit rewrite = 0, frag = 0, stall_mem = 0, stall_tx = 0, hold_tx = 0, held_prev = 0;
    int rsp_left = 0, rsp_idx = 0, rsp_delay = 0, req_seen = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // One clock of model: check outputs, then drive the next inputs.
    task automatic step();
        logic [31:0] w2;
        @(negedge clk);
        cyc++;
        if (rst_n) begin
            chk(status_word == (32'(exp_cons) << 16), "R8", 64'(status_word), 64'(32'(exp_cons) << 16));
            if (rd_req_valid) begin
                req_seen++;
                chk(prod_m != exp_cons, "R2", 64'(prod_m), 64'(exp_cons));
                chk(rd_req_addr == BASE + 64'(exp_cons) * 64'd16,
                    (exp_cons == 0 && done_cnt > 0) ? "R9" : "R3",
                    rd_req_addr, BASE + 64'(exp_cons) * 64'd16);
            end
            if (tx_valid) begin
                w2 = mem_w[exp_cons][2];
                chk(tx_addr == {mem_w[exp_cons][0], mem_w[exp_cons][1]}, stall_mem ? "R4" : "R5",
                    tx_addr, {mem_w[exp_cons][0], mem_w[exp_cons][1]});
                chk(tx_len == w2[31:16], held_prev ? "R7" : "R5", 64'(tx_len), 64'(w2[31:16]));
                chk(tx_flags == w2[15:0], "R11", 64'(tx_flags), 64'(w2[15:0]));
                chk(tx_last == w2[2], w2[2] ? "R5" : "R6", 64'(tx_last), 64'(w2[2]));
            end
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mbox_wr = 1'b0;
        if (rst_n && post_req > 0) begin
            for (int k = 0; k < post_req; k++) begin
                int ix;
                ix = (prod_m + k) % RING;
                mem_w[ix][0] = 32'hA000_0000 | 32'(seq);
                mem_w[ix][1] = 32'(seq) * 32'h1000 + 32'h40;
                mem_w[ix][2] = {16'(60 + (seq * 37) % 1400), 8'(seq * 3), 5'(seq),
                                (frag ? (seq % 4 == 3) : 1'b1), 2'(seq)};
                mem_w[ix][3] = 32'hDEAD_0000 ^ 32'(seq * 7 + 1);
                seq++;
            end
            prod_m = (prod_m + post_req) % RING;
            mbox_wr = 1'b1;
            mbox_idx = 9'(prod_m);
            post_req = 0;
        end else if (rst_n && rewrite) begin
            mbox_wr = 1'b1;
            mbox_idx = 9'(prod_m);
            rewrite = 0;
        end
        rd_req_ready = stall_mem ? lfsr[0] : 1'b1;
        if (rsp_left > 0 && rsp_delay == 0 && !(stall_mem && lfsr[1])) begin
            rd_rsp_valid = 1'b1;
            rd_rsp_data = mem_w[rsp_idx][4 - rsp_left];
            rsp_left--;
        end else begin
            rd_rsp_valid = 1'b0;
            rd_rsp_data = 32'h5A5A_5A5A;
            if (rsp_left > 0 && rsp_delay > 0) rsp_delay--;
        end
        if (rst_n && rd_req_valid && rd_req_ready && rsp_left == 0) begin
            rsp_left = 4;
            rsp_idx = int'(((rd_req_addr - BASE) >> 4) % 64'(RING));
            rsp_delay = stall_mem ? int'(lfsr[3:2]) : 0;
        end
        tx_ready = hold_tx ? 1'b0 : (stall_tx ? lfsr[4] : 1'b1);
        held_prev = tx_valid && !tx_ready;
        if (rst_n && tx_valid && tx_ready) begin
            exp_cons = (exp_cons + 1) % RING;
            done_cnt++;
            if (exp_cons == 0) wraps++;
        end
    endtask

    task automatic post(input int n);
        post_req = n;
        step();
    endtask

    task automatic wait_idle(input string tag);
        int guard;
        guard = 0;
        while (!(exp_cons == prod_m && !tx_valid && !rd_req_valid && rsp_left == 0)) begin
            step();
            guard++;
            if (guard > 30000) begin
                chk(1'b0, tag, 64'(exp_cons), 64'(prod_m));
                break;
            end
        end
    endtask

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base_done;
        // R1: state during and right after reset
        repeat (4) step();
        chk(status_word == 32'h0, "R1", 64'(status_word), 64'h0);
        chk(!rd_req_valid && !tx_valid, "R1", {62'h0, rd_req_valid, tx_valid}, 64'h0);
        rst_n = 1'b1;
        step();
        chk(status_word == 32'h0, "R1", 64'(status_word), 64'h0);
        chk(!rd_req_valid && !tx_valid, "R1", {62'h0, rd_req_valid, tx_valid}, 64'h0);

        // R2: nothing posted, engine idles
        req_seen = 0;
        repeat (20) step();
        chk(req_seen == 0, "R2", 64'(req_seen), 64'h0);

        // Single complete frame
        post(1);
        wait_idle("R3");
        chk(done_cnt == 1, "R3", 64'(done_cnt), 64'h1);

        // R6: fragments with end-of-frame only on every fourth slot
        frag = 1;
        post(8);
        wait_idle("R6");
        frag = 0;

        // R4/R7: back-pressure on every handshake
        stall_mem = 1; stall_tx = 1;
        post(20);
        wait_idle("R4");

        // R2: rewriting the current producer value starts nothing
        rewrite = 1;
        req_seen = 0;
        repeat (20) step();
        chk(req_seen == 0, "R2", 64'(req_seen), 64'h0);

        // R10: full ring posted at once while the MAC side stalls
        hold_tx = 1;
        post(RING - 1);
        repeat (40) step();
        chk(tx_valid == 1'b1, "R7", 64'(tx_valid), 64'h1);
        chk(done_cnt == 29, "R8", 64'(done_cnt), 64'd29);
        base_done = done_cnt;
        hold_tx = 0;
        wait_idle("R10");
        chk(done_cnt - base_done == RING - 1, "R10", 64'(done_cnt - base_done), 64'(RING - 1));
        chk(wraps >= 1, "R9", 64'(wraps), 64'h1);

        // Streaming with mixed sizes and fragments across another wrap
        frag = 1;
        begin
            int posted;
            posted = 0;
            while (posted < 300) begin
                int fr;
                int n;
                fr = (exp_cons - prod_m - 1 + 2 * RING) % RING;
                n = (fr < 37) ? fr : 37;
                if (n > 0) begin
                    post(n);
                    posted += n;
                end
                repeat (5) step();
            end
        end
        wait_idle("R9");
        chk(done_cnt == 29 + RING - 1 + 300 || done_cnt >= 29 + RING - 1 + 300, "R9",
            64'(done_cnt), 64'(29 + RING - 1 + 300));
        chk(status_word == (32'(prod_m) << 16), "R8", 64'(status_word), 64'(32'(prod_m) << 16));

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule